// File: doc/BRIEF.md
# Text-Mode Character Cell Pixel Generator

This block turns a screen of character codes into a serial pixel stream for a 256 by 192 raster. The external raster counter supplies the horizontal and vertical pixel counts and a blanking flag. Each 8-pixel-wide cell is looked up in a character code memory. A computed glyph ROM then turns the code and the line inside the cell into one 8-bit glyph row, and that row is shifted out one pixel per clock. Sync is generated elsewhere.

A host can write the character code memory on any cycle through its own write port, while the display keeps reading. The cell height is a parameter. With 16-line cells the screen is 32 by 12 characters. With 12-line cells it is 32 by 16 characters. In 12-line mode the raster line is split into a text row and a line-in-cell by arithmetic rather than by slicing bits.

A small fetch sequencer runs the pipeline. Its states are `S_IDLE`, `S_LOAD` and `S_SHIFT`. After reset it waits in `S_IDLE`. A fetch cycle (horizontal count modulo 8 equal to 6) moves it from `S_IDLE` or `S_SHIFT` into `S_LOAD`. In `S_LOAD` the glyph row enters the shifter at the next edge, and the sequencer then moves to `S_SHIFT`, or back to `S_LOAD` if that cycle is itself a fetch cycle. `S_SHIFT` stays in `S_SHIFT` until the next fetch cycle.

Top module: `txtcell_display`

## Requirements
- R1: While reset is asserted the pixel output is 0, even with blanking low.
- R2: The pixel output is 0 on every cycle on which the blanking input is 1.
- R3: Cells are 8 pixels wide. The cell for pixel column h is column h/8 (32 columns), and its code sits at memory address text_row*32 + column.
- R4: With CELL_ROWS=16, the text row is v/16 and the line in the cell is v mod 16 (12 text rows).
- R5: With CELL_ROWS=12, the text row is v/12 and the line in the cell is v mod 12 (16 text rows).
- R6: The glyph row for code c and line l is (((c mod 128)*2 + 1) XOR (l*17)) mod 256.
- R7: Glyph row bit 7 is shown at h mod 8 = 0, then bit 6, and so on down to bit 0 at h mod 8 = 7. Each cell's row is in place on the cycle where h mod 8 = 0.
- R8: Column 0 of a line is fetched at the end of the previous line, using the next line index, which wraps from V_TOTAL-1 to 0. The line length must be a multiple of 8 and longer than SCREEN_W.
- R9: A host write is accepted on any cycle. It takes effect for every fetch after its clock edge and never alters the code being read for display.
- R10: Code bit 7 does not select a glyph: codes c and c+128 give the same glyph.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcount | input | 9 | Horizontal pixel count from the raster counter |
| vcount | input | 8 | Vertical line count from the raster counter |
| blank | input | 1 | Blanking active, forces pixel to 0 |
| wr_en | input | 1 | Host write strobe for the code memory |
| wr_addr | input | 9 | Host write address (text_row*32 + column) |
| wr_data | input | 8 | Character code to store |
| pix_out | output | 1 | Serial pixel |

## Verification
On every cycle the assertions check four things. A fetch cycle is always followed by `S_LOAD`. The pixel after a load equals bit 7 of the glyph row presented at that load. The code memory's read data stays stable when no read is issued, whatever is being written. In 12-line mode, the remapped row and line recombine exactly into the raster line. Only the bench scenarios can show the rest. These are the full pixel image for both cell heights, the column-0 prefetch across line and frame wrap, codes with bit 7 set, and host writes made during the active picture and during vertical blanking that later show up on screen.

// File: rtl/txtcell_pkg.sv
package txtcell_pkg;
    localparam int CELL_W = 8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LOAD  = 2'd1,
        S_SHIFT = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/txtcell_rowmap.sv
module txtcell_rowmap #(
    parameter int VW        = 8,
    parameter int CELL_ROWS = 16,
    parameter int RW        = 5,
    parameter int LW        = 4
) (
    input  logic [VW-1:0] v_i,
    output logic [RW-1:0] row_o,
    output logic [LW-1:0] line_o
);
    localparam int MAXR = ((1 << VW) + CELL_ROWS - 1) / CELL_ROWS;

    generate
        if ((CELL_ROWS & (CELL_ROWS - 1)) == 0) begin : g_slice
            localparam int SH = $clog2(CELL_ROWS);
            assign row_o  = RW'(v_i >> SH);
            assign line_o = LW'(v_i[SH-1:0]);
        end else begin : g_remap
            always_comb begin
                int vi;
                int r;
                vi = int'(v_i);
                r  = 0;
                for (int i = 1; i < MAXR; i++) begin
                    if (vi >= i * CELL_ROWS) r = i;
                end
                row_o  = RW'(r);
                line_o = LW'(vi - r * CELL_ROWS);
            end

            always_comb begin
                // R5
                remap_range_chk: assert ((int'(line_o) < CELL_ROWS) &&
                    (int'(row_o) * CELL_ROWS + int'(line_o) == int'(v_i)))
                    else $error("row remap out of range");
            end
        end
    endgenerate
endmodule

// File: rtl/txtcell_codemem.sv
module txtcell_codemem #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem_q[raddr];
    end

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));
endmodule

// File: rtl/txtcell_glyphrom.sv
module txtcell_glyphrom #(
    parameter int CODE_W      = 8,
    parameter int LW          = 4,
    parameter int GLYPH_CODES = 128
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [LW-1:0]     line_i,
    output logic [7:0]        bits_o
);
    always_comb begin
        int idx;
        idx    = int'(code_i) % GLYPH_CODES;
        bits_o = 8'(idx * 2 + 1) ^ 8'(int'(line_i) * 17);
    end
endmodule

// File: rtl/txtcell_display.sv
module txtcell_display
    import txtcell_pkg::*;
#(
    parameter int SCREEN_W    = 256,
    parameter int SCREEN_H    = 192,
    parameter int V_TOTAL     = 200,
    parameter int CELL_ROWS   = 16,
    parameter int GLYPH_CODES = 128,
    parameter int CODE_DEPTH  = 512,
    parameter int HW          = 9,
    parameter int VW          = 8,
    parameter int CODE_W      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [HW-1:0]                 hcount,
    input  logic [VW-1:0]                 vcount,
    input  logic                          blank,
    input  logic                          wr_en,
    input  logic [$clog2(CODE_DEPTH)-1:0] wr_addr,
    input  logic [CODE_W-1:0]             wr_data,
    output logic                          pix_out
);
    localparam int COLS = SCREEN_W / CELL_W;
    localparam int CW   = $clog2(COLS);
    localparam int AW   = $clog2(CODE_DEPTH);
    localparam int LW   = $clog2(CELL_ROWS);
    localparam int RW   = $clog2(((1 << VW) + CELL_ROWS - 1) / CELL_ROWS);
    localparam int SUBW = $clog2(CELL_W);

    fetch_state_e     state_q, state_d;
    logic             fetch_now, wrap_col, sh_load, sh_shift;
    logic [VW-1:0]    v_next, v_fetch;
    logic [CW-1:0]    col_fetch;
    logic [RW-1:0]    row_fetch;
    logic [LW-1:0]    line_fetch, line_q;
    logic [AW-1:0]    rd_addr;
    logic [CODE_W-1:0] code_q;
    logic [7:0]       glyph_bits, shreg_q;

    // fetch address: next cell, or column 0 of the next line at the wrap
    assign fetch_now = (hcount[SUBW-1:0] == SUBW'(CELL_W - 2));
    assign wrap_col  = (int'(hcount) >= SCREEN_W - CELL_W);
    assign v_next    = (int'(vcount) == V_TOTAL - 1) ? '0 : vcount + 1'b1;
    assign v_fetch   = wrap_col ? v_next : vcount;
    assign col_fetch = wrap_col ? '0 : CW'(hcount[HW-1:SUBW]) + 1'b1;
    assign rd_addr   = AW'(int'(row_fetch) * COLS + int'(col_fetch));

    txtcell_rowmap #(
        .VW(VW), .CELL_ROWS(CELL_ROWS), .RW(RW), .LW(LW)
    ) rowmap_i (
        .v_i(v_fetch), .row_o(row_fetch), .line_o(line_fetch)
    );

    txtcell_codemem #(
        .DEPTH(CODE_DEPTH), .DW(CODE_W), .AW(AW)
    ) codemem_i (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .re(fetch_now), .raddr(rd_addr), .rdata(code_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)         line_q <= '0;
        else if (fetch_now) line_q <= line_fetch;
    end

    txtcell_glyphrom #(
        .CODE_W(CODE_W), .LW(LW), .GLYPH_CODES(GLYPH_CODES)
    ) glyphrom_i (
        .code_i(code_q), .line_i(line_q), .bits_o(glyph_bits)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = fetch_now ? S_LOAD : S_IDLE;
            S_LOAD:  state_d = fetch_now ? S_LOAD : S_SHIFT;
            S_SHIFT: state_d = fetch_now ? S_LOAD : S_SHIFT;
            default: state_d = S_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_LOAD:  sh_load  = 1'b1;
            S_SHIFT: sh_shift = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        shreg_q <= '0;
        else if (sh_load)  shreg_q <= glyph_bits;
        else if (sh_shift) shreg_q <= {shreg_q[6:0], 1'b0};
    end

    assign pix_out = shreg_q[7] & ~blank;

    // R7
    fetch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_now |=> state_q == S_LOAD);

    // R7
    pix_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == S_LOAD) && !blank |-> pix_out == $past(glyph_bits[7]));
endmodule

// File: tb/txtcell_display_tb_top.sv
`timescale 1ns/1ps
module txtcell_display_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] hcount = '0;
    logic [7:0] vcount = 8'd199;
    logic       blank = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pix16, pix12;

    int mem [512];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    txtcell_display #(.CELL_ROWS(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
        .blank(blank), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_out(pix16));

    txtcell_display #(.CELL_ROWS(12)) dut12_i (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
        .blank(blank), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_out(pix12));

    // R6 glyph content, R10 bit 7 of code ignored
    function automatic int glyph(int code, int line);
        return ((((code % 128) * 2) + 1) ^ (line * 17)) & 255;
    endfunction

    // R3 cell address, R4/R5 row split, R7 bit order
    function automatic int ref_pix(int h, int v, int cr);
        int a;
        a = (v / cr) * 32 + h / 8;
        return (glyph(mem[a], v % cr) >> (7 - (h % 8))) & 1;
    endfunction

    task automatic check(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s h=%0d v=%0d actual=%0d expected=%0d",
                     tag, hcount, vcount, act, exp);
        end
    endtask

    function automatic string tag_for(int h, int v, int cr);
        string t;
        int a;
        a = (v / cr) * 32 + h / 8;
        t = (cr == 16) ? "R4/R3/R6/R7" : "R5/R3/R6/R7";
        if (h < 8) t = {t, "/R8"};
        if (mem[a] >= 128) t = {t, "/R10"};
        if (a >= 480 || a < 64) t = {t, "/R9"};
        return t;
    endfunction

    initial begin
        #(4 * 250000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // preload all cells while in reset; some codes have bit 7 set (R10)
        for (int a = 0; a < 512; a++) begin
            @(posedge clk); #1;
            wr_en = 1'b1;
            wr_addr = 9'(a);
            wr_data = 8'((a * 37 + 5) & 255);
            mem[a] = (a * 37 + 5) & 255;
        end
        @(posedge clk); #1;
        wr_en = 1'b0;
        blank = 1'b0;
        @(negedge clk);
        check(int'(pix16), 0, "R1 (16-line)");
        check(int'(pix12), 0, "R1 (12-line)");
        @(posedge clk); #1;
        blank = 1'b1;
        rst_n = 1'b1;

        // preroll line 199 (R8 wrap to 0), full frame, then 48 lines
        for (int n = 0; n < 1 + 200 + 48; n++) begin
            int v;
            v = (n == 0) ? 199 : (n - 1) % 200;
            for (int h = 0; h < 320; h++) begin
                @(posedge clk); #1;
                hcount = 9'(h);
                vcount = 8'(v);
                blank  = (h >= 256 || v >= 192);
                wr_en  = 1'b0;
                // R9: writes during active lines into row 15 (shown later, 12-line only)
                if (n >= 1 && n <= 200 && v < 16 && h < 256) begin
                    wr_en = 1'b1;
                    wr_addr = 9'(480 + h % 32);
                    wr_data = 8'((h * 7 + v) & 255);
                    mem[480 + h % 32] = (h * 7 + v) & 255;
                end
                // R9: rewrite first cells during vertical blanking, shown next frame
                if (n >= 1 && n <= 200 && v == 195 && h < 64) begin
                    wr_en = 1'b1;
                    wr_addr = 9'(h);
                    wr_data = 8'((h * 11 + 200) & 255);
                    mem[h] = (h * 11 + 200) & 255;
                end
                @(negedge clk);
                if (blank) begin
                    check(int'(pix16), 0, "R2 (16-line)");
                    check(int'(pix12), 0, "R2 (12-line)");
                end else if (n >= 1) begin
                    check(int'(pix16), ref_pix(h, v, 16), tag_for(h, v, 16));
                    check(int'(pix12), ref_pix(h, v, 12), tag_for(h, v, 12));
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule